// File: doc/BRIEF.md
# Phase-Accumulator PWM Generator with Deferred Reload

A single-channel pulse-width modulator controlled through one 32-bit control word. A write port loads the word and a read port always presents it. A 16-bit frequency step is added every clock to a 16-bit phase accumulator that wraps modulo 65536. The output frequency is therefore the clock rate times the step divided by 65536, and each carry out of the accumulator ends one PWM period. The duty cycle comes from an 8-bit threshold compared against the accumulator's top byte. The threshold is written inverted: a smaller value gives a longer high time.

Software writes new step and threshold values into shadow fields. The running waveform keeps its active copies until software sets the reload-request bit. The shadow values are then copied into the active copies at the next period boundary, and the hardware clears the request bit. When the enable bit rises, the accumulator restarts from zero and a pending reload is applied at once. Clearing the enable bit forces the output low and keeps all programmed fields. The register port is plain control: a write completes in one cycle and never stalls, so it has no valid/ready handshake and no back-pressure.

Top module: `phase_pwm`

## Requirements
- R1: After reset the read-back word is 0x00000000 and `pwm_out` is low.
- R2: The read-back word is laid out as follows: bit 31 holds the enable bit, bit 30 the pending reload request, bits 23:8 the shadow step and bits 7:0 the shadow threshold. All other bits read 0. A write updates the word from the next cycle.
- R3: A written step above 0x8002 is stored as 0x8002 (saturation, the default variant). A step of 0x8002 or below is stored as written.
- R4: While running, the accumulator adds the active step every clock. A carry out of bit 15 ends a period, so with step 0x1000 the output rises once every 16 cycles.
- R5: While running, `pwm_out` is high exactly when accumulator bits 15:8 are greater than or equal to the active threshold. Step 0x1000 with threshold 0x80 gives 8 high cycles in every 16.
- R6: Writing the step or threshold with bit 30 clear does not change the running waveform.
- R7: A write with bit 30 set raises the pending flag. At the next period boundary the shadow fields become active and the flag reads 0. Writing bit 30 as 0 does not clear the flag.
- R8: While the enable bit is 0, `pwm_out` is low from the cycle after the write that cleared it, and the step and threshold fields keep their values.
- R9: On a 0-to-1 change of the enable bit, the accumulator restarts from 0 and a pending reload is applied at once. The first output cycle, two clocks after the write, uses the new values with accumulator 0. While disabled, a pending request stays pending.
- R10: Rewriting the word with the enable bit already 1 does not restart the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Write strobe for the control word |
| reg_wr_data | input | 32 | Control word to write |
| reg_rd_data | output | 32 | Current control word read-back |
| pwm_out | output | 1 | PWM output |

## Verification
The read-back word changes one clock after a write. A disable shows on `pwm_out` one clock after its write. An enable shows two clocks after its write, because one edge detects the rising enable and applies any pending reload. A reload request clears on the edge that produces the accumulator carry, at most one period after the request. A behavioural reference model in the bench advances on the same clock edges as the design and is compared on every falling edge, so each result is sampled half a cycle after the edge that produces it. The directed checks count high cycles and rising edges over windows of whole periods, which makes their expected totals independent of where in a period the window starts.

// File: rtl/phase_pwm_pkg.sv
package phase_pwm_pkg;
  localparam int REG_W   = 32;
  localparam int ACC_W   = 16;
  localparam int INC_W   = ACC_W;
  localparam int DIV_W   = 8;
  localparam int EN_BIT  = 31;
  localparam int UPD_BIT = 30;
  localparam int INC_LSB = 8;
  localparam int DIV_LSB = 0;
  localparam logic [INC_W-1:0] INC_MAX = 16'h8002;

  typedef struct packed {
    logic [INC_W-1:0] inc;
    logic [DIV_W-1:0] div;
  } pwm_cfg_t;

  function automatic logic [INC_W-1:0] clamp_inc(input logic [INC_W-1:0] v);
    return (v > INC_MAX) ? INC_MAX : v;
  endfunction
endpackage

// File: rtl/pwm_shadow_regs.sv
module pwm_shadow_regs
  import phase_pwm_pkg::*;
#(
  parameter bit OVER_RANGE_DROP = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             xfer,
  output logic             en,
  output logic             pend,
  output pwm_cfg_t         shadow,
  output logic [REG_W-1:0] rd_data
);
  localparam logic [REG_W-1:0] USED_MASK =
    (REG_W'(1) << EN_BIT) | (REG_W'(1) << UPD_BIT) |
    (((REG_W'(1) << INC_W) - REG_W'(1)) << INC_LSB) |
    (((REG_W'(1) << DIV_W) - REG_W'(1)) << DIV_LSB);

  logic [INC_W-1:0] wr_inc;
  logic [INC_W-1:0] next_inc;
  logic             unused_pad;

  assign wr_inc     = wr_data[INC_LSB +: INC_W];
  assign unused_pad = |(wr_data & ~USED_MASK);

  generate
    if (OVER_RANGE_DROP) begin : g_drop
      assign next_inc = (wr_inc > INC_MAX) ? shadow.inc : wr_inc;
    end else begin : g_sat
      assign next_inc = clamp_inc(wr_inc);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en     <= 1'b0;
      pend   <= 1'b0;
      shadow <= '0;
    end else begin
      if (xfer) pend <= 1'b0;
      if (wr_en) begin
        en         <= wr_data[EN_BIT];
        if (wr_data[UPD_BIT]) pend <= 1'b1;
        shadow.inc <= next_inc;
        shadow.div <= wr_data[DIV_LSB +: DIV_W];
      end
    end
  end

  always_comb begin
    rd_data                    = '0;
    rd_data[EN_BIT]            = en;
    rd_data[UPD_BIT]           = pend;
    rd_data[INC_LSB +: INC_W]  = shadow.inc;
    rd_data[DIV_LSB +: DIV_W]  = shadow.div;
  end
endmodule

// File: rtl/pwm_active_regs.sv
module pwm_active_regs
  import phase_pwm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  pwm_cfg_t shadow,
  output pwm_cfg_t active
);
  always_ff @(posedge clk) begin
    if (!rst_n)    active <= '0;
    else if (load) active <= shadow;
  end
endmodule

// File: rtl/pwm_phase_acc.sv
module pwm_phase_acc
  import phase_pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [INC_W-1:0] inc,
  output logic [ACC_W-1:0] acc,
  output logic             run,
  output logic             start,
  output logic             wrap
);
  logic             en_d;
  logic [ACC_W:0]   sum;

  assign run   = en & en_d;
  assign start = en & ~en_d;
  assign sum   = {1'b0, acc} + {1'b0, inc};
  assign wrap  = run & sum[ACC_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_d <= 1'b0;
      acc  <= '0;
    end else begin
      en_d <= en;
      acc  <= run ? sum[ACC_W-1:0] : '0;
    end
  end
endmodule

// File: rtl/pwm_threshold.sv
module pwm_threshold
  import phase_pwm_pkg::*;
(
  input  logic             run,
  input  logic [ACC_W-1:0] acc,
  input  logic [DIV_W-1:0] div,
  output logic             out
);
  assign out = run & (acc[ACC_W-1 -: DIV_W] >= div);
endmodule

// File: rtl/phase_pwm.sv
module phase_pwm
  import phase_pwm_pkg::*;
#(
  parameter bit OVER_RANGE_DROP = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_en,
  input  logic [REG_W-1:0] reg_wr_data,
  output logic [REG_W-1:0] reg_rd_data,
  output logic             pwm_out
);
  logic             en, pend, run, start, wrap, xfer;
  pwm_cfg_t         shadow_cfg, act_cfg;
  logic [ACC_W-1:0] acc;

  assign xfer = pend & (start | wrap);

  pwm_shadow_regs #(.OVER_RANGE_DROP(OVER_RANGE_DROP)) u_shadow (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wr_data(reg_wr_data),
    .xfer(xfer), .en(en), .pend(pend), .shadow(shadow_cfg), .rd_data(reg_rd_data)
  );

  pwm_active_regs u_active (
    .clk(clk), .rst_n(rst_n), .load(xfer), .shadow(shadow_cfg), .active(act_cfg)
  );

  pwm_phase_acc u_acc (
    .clk(clk), .rst_n(rst_n), .en(en), .inc(act_cfg.inc),
    .acc(acc), .run(run), .start(start), .wrap(wrap)
  );

  pwm_threshold u_cmp (
    .run(run), .acc(acc), .div(act_cfg.div), .out(pwm_out)
  );
endmodule

// File: rtl/phase_pwm_chk.sv
module phase_pwm_chk
  import phase_pwm_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr_en,
  input logic [REG_W-1:0] reg_rd_data,
  input logic             pwm_out,
  input pwm_cfg_t         act_cfg,
  input logic [ACC_W-1:0] acc
);
  // R8
  dis_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd_data[EN_BIT] |-> !pwm_out);

  // R3
  inc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_data[INC_LSB +: INC_W] <= INC_MAX);

  // R9
  idle_acc_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd_data[EN_BIT] |=> (acc == '0));

  // R6
  hold_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd_data[UPD_BIT] |=> $stable(act_cfg));

  // R7
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr_en && reg_rd_data[UPD_BIT] && !reg_rd_data[EN_BIT]) |=> reg_rd_data[UPD_BIT]);
endmodule

bind phase_pwm phase_pwm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_data(reg_rd_data),
  .pwm_out(pwm_out), .act_cfg(act_cfg), .acc(acc)
);

// File: tb/phase_pwm_bench.sv
`timescale 1ns/1ps
module phase_pwm_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        pwm_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  phase_pwm u_phase_pwm (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(wr_en), .reg_wr_data(wr_data),
    .reg_rd_data(rd_data), .pwm_out(pwm_out)
  );

  // behavioural reference model
  bit m_en, m_end, m_pend;
  int m_sinc, m_sdiv, m_ainc, m_adiv, m_acc;
  bit t_run, t_start, t_wrap, t_xfer;
  int t_sum;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_end = 0; m_pend = 0;
      m_sinc = 0; m_sdiv = 0; m_ainc = 0; m_adiv = 0; m_acc = 0;
    end else begin
      t_run   = m_en && m_end;
      t_start = m_en && !m_end;
      t_sum   = m_acc + m_ainc;
      t_wrap  = t_run && (t_sum >= 65536);
      t_xfer  = m_pend && (t_start || t_wrap);
      m_acc   = t_run ? (t_sum % 65536) : 0;
      m_end   = m_en;
      if (t_xfer) begin
        m_ainc = m_sinc; m_adiv = m_sdiv; m_pend = 0;
      end
      if (wr_en) begin
        m_en = wr_data[31];
        if (wr_data[30]) m_pend = 1;
        m_sinc = (int'(wr_data[23:8]) > 32770) ? 32770 : int'(wr_data[23:8]);
        m_sdiv = int'(wr_data[7:0]);
      end
    end
  end

  function automatic logic [31:0] model_rd();
    return {m_en, m_pend, 6'b0, 16'(m_sinc), 8'(m_sdiv)};
  endfunction

  function automatic logic model_out();
    return m_en && m_end && ((m_acc >> 8) >= m_adiv);
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (pwm_out !== model_out() || rd_data !== model_rd()) begin
        fails++;
        $display("FAIL R2 R4 R5 R10 model: out=%0b rd=%h expected out=%0b rd=%h",
                 pwm_out, rd_data, model_out(), model_rd());
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input bit en, input bit upd, input int inc, input int div);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = {en, upd, 6'b0, 16'(inc), 8'(div)};
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic count_high(input int n, output int highs, output int rises);
    logic prev = 1'b0;
    highs = 0; rises = 0;
    for (int i = 0; i < n; i++) begin
      if (pwm_out) highs++;
      if (pwm_out && !prev) rises++;
      prev = pwm_out;
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    int h, r, w;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset readback", int'(rd_data), 0);
    check("R1 reset output", int'(pwm_out), 0);

    wr(0, 0, 16'hFFFF, 8'h80);
    check("R3 step saturates", int'(rd_data[23:8]), 16'h8002);
    check("R2 word layout", int'(rd_data), 32'h0080_0280);
    wr(0, 0, 16'h8002, 8'h80);
    check("R3 limit kept", int'(rd_data[23:8]), 16'h8002);

    wr(0, 1, 16'h1000, 8'h80);
    check("R2 pending layout", int'(rd_data), 32'h4010_0080);
    repeat (10) @(negedge clk);
    check("R9 pending held while disabled", int'(rd_data[30]), 1);

    wr(1, 0, 16'h1000, 8'h80);
    check("R7 bit30 zero does not clear", int'(rd_data[30]), 1);
    @(negedge clk);
    check("R9 reload applied on enable", int'(rd_data[30]), 0);
    check("R9 first cycle accumulator zero", int'(pwm_out), 0);
    count_high(160, h, r);
    check("R5 duty 8 of 16", h, 80);
    check("R4 one rise per 16 cycles", r, 10);

    wr(1, 0, 16'h1000, 8'hC0);
    check("R6 shadow visible", int'(rd_data[7:0]), 8'hC0);
    count_high(160, h, r);
    check("R6 waveform unchanged", h, 80);

    wr(1, 1, 16'h1000, 8'hC0);
    check("R7 request raised", int'(rd_data[30]), 1);
    w = 0;
    while (rd_data[30] && w < 40) begin
      @(negedge clk);
      w++;
    end
    check("R7 cleared within one period", int'(w <= 16), 1);
    count_high(160, h, r);
    check("R7 new duty 4 of 16", h, 40);

    wr(1, 0, 16'h1000, 8'hC0);
    count_high(160, h, r);
    check("R10 rewrite keeps waveform", h, 40);

    wr(0, 0, 16'h1000, 8'hC0);
    check("R8 low after disable", int'(pwm_out), 0);
    count_high(50, h, r);
    check("R8 stays low", h, 0);
    check("R8 fields kept", int'(rd_data), 32'h0010_00C0);

    wr(0, 1, 16'h2000, 8'h00);
    repeat (5) @(negedge clk);
    check("R9 pending while disabled", int'(rd_data[30]), 1);
    wr(1, 0, 16'h2000, 8'h00);
    @(negedge clk);
    count_high(64, h, r);
    check("R9 immediate reload threshold 0", h, 64);

    wr(0, 1, 16'h1000, 8'hF0);
    wr(1, 0, 16'h1000, 8'hF0);
    @(negedge clk);
    count_high(15, h, r);
    check("R9 restart from zero low phase", h, 0);
    check("R9 restart from zero first high", int'(pwm_out), 1);

    wr(1, 1, 16'hFFFF, 8'h40);
    repeat (200) @(negedge clk);
    check("R3 saturated step while running", int'(rd_data[23:8]), 16'h8002);

    finish_run();
  end
endmodule